// File: doc/BRIEF.md
# Scaled-Displacement Effective Address Generator

This block forms the effective address of a load or store in a 32-bit pipeline. A request strobe comes with four inputs: an addressing mode, an operand size, a raw displacement field, and three candidate operands. The operands are the selected general register, the index register and the global base register. One clock later the block presents the registered address with a valid flag. It also reports whether the access breaks natural alignment and whether the size code is illegal.

There are four modes. Two add a displacement to a base: a general register with a short field, or the global base with a long field. The displacement is always zero-extended and then scaled by the access width in bytes. The other two modes add the index register to either base with no scaling. The sum wraps modulo 2^32.

A two-state controller, `ST_IDLE` and `ST_ISSUE`, sequences the output. A request in either state moves it to `ST_ISSUE` (transition `T_REQ`), where the valid flag is high. A cycle without a request returns it to `ST_IDLE` (transition `T_DRAIN`). Reset forces `ST_IDLE` (transition `T_RESET`).

Top module: `scaled_agu`

## Requirements
- R1: On synchronous reset (rst high at a clock edge) the address output becomes 0, and valid, misalign and size-error all become 0, whatever req is.
- R2: valid is high in the cycle after each clock edge where req is high, and low after an edge where req is low; with req low the address output keeps its last value.
- R3: Mode 2'b00 (register + short displacement): address = base_i + (zero-extended disp_i[3:0] scaled by size); disp_i[7:4] has no effect.
- R4: Mode 2'b01 (register indexed): address = base_i + index_i, unscaled; disp_i has no effect.
- R5: Mode 2'b10 (global + long displacement): address = gbase_i + (zero-extended disp_i[7:0] scaled by size).
- R6: Mode 2'b11 (global indexed): address = gbase_i + index_i, unscaled; disp_i has no effect.
- R7: Size code 2'b00 = byte (scale 1), 2'b01 = word (scale 2), 2'b10 = longword (scale 4); the short field reaches 15/30/60 bytes and the long field reaches 255/510/1020 bytes.
- R8: The addition is modulo 2^32; a carry out of bit 31 is discarded.
- R9: misalign is set with valid when a word access has address bit 0 set, or when a longword access has bit 1 or bit 0 set; byte accesses never set it.
- R10: Size code 2'b11 sets size_err with valid, uses a scale of 1 and never sets misalign.
- R11: misalign and size_err are low in every cycle where valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe |
| mode_i | input | 2 | Addressing mode |
| size_i | input | 2 | Operand size code |
| disp_i | input | 8 | Raw displacement field |
| base_i | input | 32 | Selected general register value |
| index_i | input | 32 | Index register value |
| gbase_i | input | 32 | Global base register value |
| ea_o | output | 32 | Registered effective address |
| ea_valid_o | output | 1 | Address valid |
| misalign_o | output | 1 | Alignment violation |
| size_err_o | output | 1 | Illegal size code |

## Verification
Each mode is first driven with all-ones displacement fields at every size. This separates the two field widths and the three scale factors. Fields with junk in the unused upper nibble, and indexed requests with non-zero displacements, show whether a mode reads bits it must ignore. Bases near 2^32 check the wrap, and small odd offsets check each alignment rule. A long seeded random run with interleaved idle cycles compares every output on every clock with a behavioural model, which exposes faults in the hold behaviour and in flag clearing.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        AM_REG_DISP = 2'b00,
        AM_REG_IDX  = 2'b01,
        AM_GBL_DISP = 2'b10,
        AM_GBL_IDX  = 2'b11
    } agu_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } agu_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } agu_state_e;

    typedef struct packed {
        logic misalign;
        logic size_err;
    } agu_flags_t;

endpackage

// File: rtl/agu_disp_scale.sv
module agu_disp_scale
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 8,
    parameter int SHORT_W = 4
) (
    input  agu_mode_e          mode,
    input  agu_size_e          size,
    input  logic [DISP_W-1:0]  disp,
    output logic [ADDR_W-1:0]  offset,
    output logic               size_bad
);
    localparam int PAD_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] field;
    logic [ADDR_W-1:0] wide;

    // Mode picks how many displacement bits are live; the rest are forced to zero.
    always_comb begin
        field = '0;
        unique case (mode)
            AM_REG_DISP: field[SHORT_W-1:0] = disp[SHORT_W-1:0];
            AM_GBL_DISP: field = disp;
            default:     field = '0;
        endcase
    end

    assign wide = {{PAD_W{1'b0}}, field};

    // Scale by the access width in bytes: a left shift of 0, 1 or 2.
    always_comb begin
        size_bad = 1'b0;
        unique case (size)
            SZ_BYTE: offset = wide;
            SZ_WORD: offset = wide << 1;
            SZ_LONG: offset = wide << 2;
            default: begin
                offset   = wide;
                size_bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/agu_sum.sv
module agu_sum
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  agu_mode_e         mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] op_a;
    logic [ADDR_W-1:0] op_b;

    always_comb begin
        unique case (mode)
            AM_REG_DISP: begin op_a = base;  op_b = offset; end
            AM_REG_IDX:  begin op_a = base;  op_b = index;  end
            AM_GBL_DISP: begin op_a = gbase; op_b = offset; end
            default:     begin op_a = gbase; op_b = index;  end
        endcase
    end

    // The result is as wide as the operands, so the carry out is dropped.
    assign sum = op_a + op_b;
endmodule

// File: rtl/agu_align.sv
module agu_align
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  agu_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    output logic              misalign
);
    always_comb begin
        unique case (size)
            SZ_WORD: misalign = addr[0];
            SZ_LONG: misalign = |addr[1:0];
            default: misalign = 1'b0;
        endcase
    end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] sum,
    input  agu_flags_t        flags_next,
    output logic [ADDR_W-1:0] ea,
    output logic              valid,
    output agu_flags_t        flags
);
    agu_state_e state_q;
    agu_state_e state_d;

    // Next-state logic: T_REQ moves to ST_ISSUE, T_DRAIN returns to ST_IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = req ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = req ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register; T_RESET forces ST_IDLE.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output registers: the address is captured on a request and held otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            ea    <= '0;
            flags <= '0;
        end else if (req) begin
            ea    <= sum;
            flags <= flags_next;
        end else begin
            flags <= '0;
        end
    end

    assign valid = (state_q == ST_ISSUE);
endmodule

// File: rtl/scaled_agu.sv
module scaled_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 8,
    parameter int SHORT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [ADDR_W-1:0] gbase_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              ea_valid_o,
    output logic              misalign_o,
    output logic              size_err_o
);
    agu_mode_e         mode;
    agu_size_e         size;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;
    logic              size_bad;
    logic              misalign_c;
    agu_flags_t        flags_next;
    agu_flags_t        flags_q;

    assign mode = agu_mode_e'(mode_i);
    assign size = agu_size_e'(size_i);

    agu_disp_scale #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_scale (
        .mode     (mode),
        .size     (size),
        .disp     (disp_i),
        .offset   (offset),
        .size_bad (size_bad)
    );

    agu_sum #(.ADDR_W(ADDR_W)) u_sum (
        .mode   (mode),
        .base   (base_i),
        .index  (index_i),
        .gbase  (gbase_i),
        .offset (offset),
        .sum    (sum)
    );

    agu_align #(.ADDR_W(ADDR_W)) u_align (
        .size     (size),
        .addr     (sum),
        .misalign (misalign_c)
    );

    assign flags_next.misalign = misalign_c;
    assign flags_next.size_err = size_bad;

    agu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .sum        (sum),
        .flags_next (flags_next),
        .ea         (ea_o),
        .valid      (ea_valid_o),
        .flags      (flags_q)
    );

    assign misalign_o = flags_q.misalign;
    assign size_err_o = flags_q.size_err;
endmodule

// File: rtl/scaled_agu_chk.sv
module scaled_agu_chk #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        size_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] index_i,
    input logic [ADDR_W-1:0] gbase_i,
    input logic [ADDR_W-1:0] ea_o,
    input logic              ea_valid_o,
    input logic              misalign_o,
    input logic              size_err_o
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_i |=> ea_valid_o); // R2

    AST_IDLE_HOLDS_EA: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!ea_valid_o && $stable(ea_o))); // R2

    AST_REG_IDX_SUM: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b01) |=> (ea_o == $past(base_i) + $past(index_i))); // R4

    AST_GBL_IDX_SUM: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b11) |=> (ea_o == $past(gbase_i) + $past(index_i))); // R6

    AST_LONG_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_i && size_i == 2'b10) |=> (misalign_o == (ea_o[1:0] != 2'b00))); // R9

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_i && size_i == 2'b01) |=> (misalign_o == ea_o[0])); // R9

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (req_i && size_i == 2'b11) |=> (size_err_o && !misalign_o)); // R10

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ea_valid_o |-> (!misalign_o && !size_err_o)); // R11
endmodule

bind scaled_agu scaled_agu_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .mode_i     (mode_i),
    .size_i     (size_i),
    .disp_i     (disp_i),
    .base_i     (base_i),
    .index_i    (index_i),
    .gbase_i    (gbase_i),
    .ea_o       (ea_o),
    .ea_valid_o (ea_valid_o),
    .misalign_o (misalign_o),
    .size_err_o (size_err_o)
);

// File: tb/tb_scaled_agu.sv
module tb_scaled_agu;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [1:0]  mode_i;
    logic [1:0]  size_i;
    logic [7:0]  disp_i;
    logic [31:0] base_i, index_i, gbase_i;
    logic [31:0] ea_o;
    logic        ea_valid_o, misalign_o, size_err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [31:0] m_ea;
    logic        m_valid, m_mis, m_err;

    always #10 clk = ~clk;

    scaled_agu dut (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
        .disp_i(disp_i), .base_i(base_i), .index_i(index_i), .gbase_i(gbase_i),
        .ea_o(ea_o), .ea_valid_o(ea_valid_o), .misalign_o(misalign_o),
        .size_err_o(size_err_o)
    );

    // Behavioural reference: arithmetic on wide integers, then reduced mod 2^32.
    function automatic logic [31:0] ref_addr(input logic [1:0] md, input logic [1:0] sz,
                                             input logic [7:0] d, input logic [31:0] b,
                                             input logic [31:0] x, input logic [31:0] g);
        longint unsigned mult, dv, tot;
        mult = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
        dv   = (md == 2'd0) ? longint'(d % 16) : longint'(d);
        case (md)
            2'd0: tot = longint'(b) + dv * mult;
            2'd1: tot = longint'(b) + longint'(x);
            2'd2: tot = longint'(g) + dv * mult;
            default: tot = longint'(g) + longint'(x);
        endcase
        return tot[31:0];
    endfunction

    function automatic logic ref_mis(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'd1) return (a % 2) != 0;
        if (sz == 2'd2) return (a % 4) != 0;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ea = 0; m_valid = 0; m_mis = 0; m_err = 0;
        end else if (req_i) begin
            m_ea    = ref_addr(mode_i, size_i, disp_i, base_i, index_i, gbase_i);
            m_valid = 1;
            m_mis   = ref_mis(size_i, m_ea);
            m_err   = (size_i == 2'd3);
        end else begin
            m_valid = 0; m_mis = 0; m_err = 0;
        end
    end

    task automatic compare(input string tag);
        n_tests++;
        if (ea_o !== m_ea || ea_valid_o !== m_valid || misalign_o !== m_mis || size_err_o !== m_err) begin
            n_fail++;
            $display("FAIL %s: ea=%h v=%b mis=%b err=%b expected ea=%h v=%b mis=%b err=%b",
                     tag, ea_o, ea_valid_o, misalign_o, size_err_o, m_ea, m_valid, m_mis, m_err);
        end
    endtask

    task automatic step(input string tag, input logic rq, input logic [1:0] md, input logic [1:0] sz,
                        input logic [7:0] d, input logic [31:0] b, input logic [31:0] x,
                        input logic [31:0] g);
        req_i = rq; mode_i = md; size_i = sz; disp_i = d; base_i = b; index_i = x; gbase_i = g;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst = 1; req_i = 1; mode_i = 0; size_i = 0; disp_i = 8'hFF;
        base_i = 32'h1234; index_i = 32'h10; gbase_i = 32'h8000;
        @(negedge clk); @(negedge clk);
        compare("R1");
        rst = 0;

        // Maximum reach per size in each displacement mode.
        for (int s = 0; s < 3; s++) begin
            step("R3", 1, 2'd0, 2'(s), 8'h0F, 32'h1000, 32'h0, 32'h0);
            step("R5", 1, 2'd2, 2'(s), 8'hFF, 32'h0, 32'h0, 32'h4000);
            step("R7", 1, 2'd0, 2'(s), 8'h01, 32'h2000, 32'h0, 32'h0);
        end
        step("R3", 1, 2'd0, 2'd2, 8'hF3, 32'h100, 32'h0, 32'h0);   // upper nibble ignored
        step("R4", 1, 2'd1, 2'd2, 8'hAB, 32'h100, 32'h24, 32'h0);   // unscaled index
        step("R6", 1, 2'd3, 2'd1, 8'h55, 32'h0, 32'h3, 32'h7000);   // unscaled index, odd
        step("R8", 1, 2'd1, 2'd0, 8'h00, 32'hFFFF_FFF0, 32'h20, 32'h0);
        step("R8", 1, 2'd2, 2'd2, 8'hFF, 32'h0, 32'h0, 32'hFFFF_FF00);
        step("R9", 1, 2'd0, 2'd1, 8'h01, 32'h1001, 32'h0, 32'h0);
        step("R9", 1, 2'd0, 2'd2, 8'h01, 32'h1002, 32'h0, 32'h0);
        step("R9", 1, 2'd1, 2'd2, 8'h00, 32'h1000, 32'h1, 32'h0);
        step("R9", 1, 2'd1, 2'd0, 8'h00, 32'h1000, 32'h3, 32'h0);
        step("R10", 1, 2'd2, 2'd3, 8'h05, 32'h0, 32'h0, 32'h1001);
        step("R11", 0, 2'd1, 2'd3, 8'h00, 32'h5, 32'h6, 32'h7);
        step("R2", 0, 2'd0, 2'd0, 8'h11, 32'h9, 32'h9, 32'h9);

        for (int k = 0; k < 400; k++)
            step("R7", 1'($urandom % 4 != 0), 2'($urandom), 2'($urandom), 8'($urandom),
                 $urandom, $urandom, $urandom);

        rst = 1; req_i = 1;
        @(negedge clk);
        compare("R1");
        rst = 0; req_i = 0;
        @(negedge clk);
        compare("R2");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule